// File: doc/BRIEF.md
# Strap-Addressed Single-Byte I2C Target

This block is the target side of a two-wire control port. Both bus lines are sampled in the system clock domain. Each line passes through a synchronizer and a majority-free agreement filter before use. From the cleaned lines the block finds START and STOP conditions and the rising and falling SCL edges. It then runs a small transaction engine that receives the address byte and answers only its own address. After that it moves exactly one data byte.

The 7-bit address is fixed except for two bits, which are taken from strap pins. One board can therefore carry up to four copies of the block. On a write, the received byte appears on a parallel output together with a one-cycle strobe. On a read, a parallel input is shifted out. SDA is never driven high: the block drives only an open-drain enable, and an external pull-up provides the high level. Bits after the single data byte are ignored until the next START or STOP.

Top module: `strap_i2c_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and `wr_valid` is 0.
- R2: An address byte equal to {0,0,1,1,1,`strap_a2`,`strap_a1`,rw}, sent MSB first after a START, is acknowledged: SDA is held low throughout the ninth SCL clock.
- R3: An address byte that does not match is not acknowledged. `sda_oe` then stays 0 until the next START.
- R4: When rw=0, the next 8 bits are sampled on the SCL rising edges, MSB first. They appear on `wr_data` with `wr_valid` high for exactly one cycle, and the byte is acknowledged in its ninth clock.
- R5: When rw=1, `rd_data` is captured at the SCL falling edge that ends the address ACK slot. It is shifted out MSB first, with the line pulled low for each 0 bit. SDA is released during the controller's ACK slot.
- R6: After the single data byte and its ACK slot, further SCL clocks cause no drive and no `wr_valid` until a START or STOP.
- R7: A START seen in any state abandons the current transfer and begins a new address reception. No byte of the abandoned transfer is reported.
- R8: After a STOP, clocked bits without a new START are not acknowledged.
- R9: A pulse on SDA or SCL shorter than FILT_LEN clock cycles has no effect on the received data or on the detection of conditions.
- R10: `sda_oe` only rises, or changes while driven, when the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_a2 | input | 1 | Address bit 2 strap |
| strap_a1 | input | 1 | Address bit 1 strap |
| rd_data | input | 8 | Byte returned on a read |
| wr_data | output | 8 | Byte received on a write |
| wr_valid | output | 1 | One-cycle strobe for wr_data |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
The controller model drives write and read transfers under two strap settings. This separates the address decode from the two strap inputs and from the R/W bit. Data bytes with mixed, all-zero and alternating patterns test bit order and sampling edge. Protocol-level patterns are also applied: a wrong address, an extra byte after the single allowed one, a START issued in the middle of a byte, and bits clocked after a STOP. These tell the acknowledge decision apart from the engine's state tracking. Short pulses placed inside a data bit show whether the filter keeps a glitch from being read as a STOP followed by a START.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD
  } tgt_state_t;

  // address byte matches prefix plus strap bits (bit 0 is the direction)
  function automatic logic addr_hit(input logic [7:0] b, input logic [4:0] prefix,
                                    input logic a2, input logic a1);
    return (b[7:3] == prefix) && (b[2] == a2) && (b[1] == a1);
  endfunction

endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      level  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)       level <= 1'b1;
      else if (~|win_q) level <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign start_evt = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_evt  = scl_f & scl_p & ~sda_p & sda_f;
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
  import i2c_tgt_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         DATA_W      = 8,
  parameter logic [4:0] ADDR_PREFIX = 5'b00111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_a2,
  input  logic              strap_a1,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_valid,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(DATA_W);

  // conditioned pins: index 1 = SCL, index 0 = SDA
  logic [1:0] raw_pins, filt_pins;
  assign raw_pins = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_pin
    i2c_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin(raw_pins[g]), .level(filt_pins[g]));
  end

  logic scl_f, sda_f;
  assign scl_f = filt_pins[1];
  assign sda_f = filt_pins[0];

  logic start_evt, stop_evt, scl_rise, scl_fall;
  i2c_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  tgt_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic              rw_q;
  logic              addr_match;

  assign addr_match = addr_hit(sh[7:0], ADDR_PREFIX, strap_a2, strap_a1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rw_q     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_data  <= '0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise && cnt != BYTE_DONE) begin
              sh  <= {sh[DATA_W-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == BYTE_DONE) begin
              rw_q <= sh[0];
              if (addr_match) begin
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (!rw_q) begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end else begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[DATA_W-1];
                state  <= ST_RD;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && cnt != BYTE_DONE) begin
              sh  <= {sh[DATA_W-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == BYTE_DONE) begin
              wr_data  <= sh;
              wr_valid <= 1'b1;
              sda_oe   <= 1'b1;
              state    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_HOLD;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                sh     <= {sh[DATA_W-2:0], 1'b0};
                sda_oe <= ~sh[DATA_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: if (scl_fall) state <= ST_HOLD;
          default: ;
        endcase
      end
    end
  end

  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state == ST_ADDR_ACK) |-> addr_match); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R3
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R4
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> (!sda_oe && !wr_valid)); // R6
  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR && !sda_oe)); // R7
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && sda_oe) |-> !scl_f); // R10
endmodule

// File: tb/sim_strap_i2c_target.sv
module sim_strap_i2c_target;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap_a2 = 1'b1, strap_a1 = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic [7:0] wr_data;
  logic wr_valid, sda_oe;
  logic line;

  always #5 clk = ~clk;
  assign line = sda_m & ~sda_oe;

  strap_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line),
    .strap_a2(strap_a2), .strap_a1(strap_a1), .rd_data(rd_data),
    .wr_data(wr_data), .wr_valid(wr_valid), .sda_oe(sda_oe));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  bit quiet = 0;
  int quiet_viol = 0, scl_viol = 0;
  logic oe_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) chk(0, "R4/R6 unexpected wr_valid", wr_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(wr_data == e, "R4 wr_data", wr_data, e);
        end
      end
      if (quiet && sda_oe) quiet_viol++;
      if (sda_oe && !oe_prev && scl_m) scl_viol++;
      oe_prev = sda_oe;
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic bit_xfer(input logic b, input bit glitch, output logic got);
    sda_m = b; wait_q(Q);
    scl_m = 1'b1; wait_q(Q / 2);
    if (glitch) begin
      sda_m = ~b; wait_q(2);
      sda_m = b;
      scl_m = 1'b0; wait_q(2);
      scl_m = 1'b1;
    end
    wait_q(Q / 2);
    got = line; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit glitch, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], glitch, g);
    bit_xfer(1'b1, 1'b0, ack);
  endtask

  task automatic rbyte(output logic [7:0] v, input logic nack);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, 1'b0, g);
      v[i] = g;
    end
    bit_xfer(nack, 1'b0, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    wait_q(4);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 reset outputs", {sda_oe, wr_valid}, 0);
    rst_n = 1'b1;
    wait_q(10);

    // R2 / R4 / R6: write under straps a2=1 a1=0 -> address 0x3C
    bus_start();
    wbyte(8'h3C, 0, ack); chk(ack == 1'b0, "R2 address ACK", ack, 0);
    exp_q.push_back(8'h5A);
    wbyte(8'h5A, 0, ack); chk(ack == 1'b0, "R4 data ACK", ack, 0);
    quiet = 1;
    wbyte(8'hFF, 0, ack); chk(ack == 1'b1, "R6 extra byte ignored", ack, 1);
    wbyte(8'h00, 0, ack); chk(ack == 1'b1, "R6 extra zero byte ignored", ack, 1);
    quiet = 0;
    bus_stop();

    // R5: read 0xA5
    rd_data = 8'hA5;
    bus_start();
    wbyte(8'h3D, 0, ack); chk(ack == 1'b0, "R2 read address ACK", ack, 0);
    rbyte(v, 1'b1); chk(v == 8'hA5, "R5 read byte", v, 8'hA5);
    quiet = 1;
    rbyte(v, 1'b1); chk(v == 8'hFF, "R6 no drive after read", v, 8'hFF);
    quiet = 0;
    bus_stop();

    // R3: mismatch (bit 2 wrong)
    bus_start();
    quiet = 1;
    wbyte(8'h38, 0, ack); chk(ack == 1'b1, "R3 mismatch no ACK", ack, 1);
    wbyte(8'h77, 0, ack); chk(ack == 1'b1, "R3 data after mismatch", ack, 1);
    quiet = 0;
    bus_stop();

    // R7: repeated START in mid-byte
    bus_start();
    wbyte(8'h3C, 0, ack);
    for (int i = 0; i < 3; i++) bit_xfer(1'b0, 0, ack);
    bus_start();
    wbyte(8'h3C, 0, ack); chk(ack == 1'b0, "R7 address after restart", ack, 0);
    exp_q.push_back(8'h81);
    wbyte(8'h81, 0, ack); chk(ack == 1'b0, "R7 data after restart", ack, 0);
    bus_stop();

    // R8: bits without START after STOP
    scl_m = 1'b0; wait_q(Q);
    quiet = 1;
    wbyte(8'h3C, 0, ack); chk(ack == 1'b1, "R8 no ACK without START", ack, 1);
    quiet = 0;
    bus_stop();

    // R2 with other straps: a2=0 a1=1 -> 0x3A
    strap_a2 = 1'b0; strap_a1 = 1'b1;
    wait_q(5);
    bus_start();
    quiet = 1;
    wbyte(8'h3C, 0, ack); chk(ack == 1'b1, "R2 old address refused", ack, 1);
    quiet = 0;
    bus_start();
    wbyte(8'h3A, 0, ack); chk(ack == 1'b0, "R2 strap address ACK", ack, 0);
    exp_q.push_back(8'hC3);
    wbyte(8'hC3, 0, ack); chk(ack == 1'b0, "R4 data ACK C3", ack, 0);
    bus_stop();

    // R9: glitches inside every data bit
    bus_start();
    wbyte(8'h3A, 0, ack);
    exp_q.push_back(8'h96);
    wbyte(8'h96, 1, ack); chk(ack == 1'b0, "R9 glitched byte ACK", ack, 0);
    bus_stop();
    wait_q(20);

    chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
    chk(quiet_viol == 0, "R3 no drive in quiet windows", quiet_viol, 0);
    chk(scl_viol == 0, "R10 drive rises only with SCL low", scl_viol, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule